// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A bank of general-purpose pins, each controlled through its own 32-bit control word. A control word holds the pin's output latch, its drive direction, an interrupt enable, a three-bit trigger mode and a flag that keeps the pin's drive state across a soft reset. Incoming pin levels pass through a two-flop synchronizer. Each pin compares its current synchronized sample with the previous one to detect edges, or matches the sample against a level. A detected event sets a sticky per-pin status bit. Software clears a status bit by writing a one.

All status bits that are both set and enabled are ORed onto a single interrupt line. One register read returns the status of the whole bank, so an interrupt handler can scan every pin at once. Separate bank-wide words return the synchronized pin inputs and the output latches. The input word shows the pin as sampled, so a value just written to the latch does not appear there until it comes back through the pad and the synchronizer. The latch word returns the written value directly.

Top module: `gpio_bank_irq`

## Requirements
- R1: After the asynchronous reset, every control word reads 0, the bank status, input and latch words read 0, and `pin_o`, `pin_oe_o` and `irq_o` are low.
- R2: The control word at address p (p < NUM_PINS) has these fields: bit0 is the output latch, bit1 is the direction (1 = drive), bit2 is the interrupt enable, bits 5:3 are the trigger mode, bit6 is keep-on-soft-reset, bit12 is status (read) or clear (write 1) and bit13 is the synchronized input (read only). All other bits read 0, and writes to them have no effect.
- R3: The input word at address NUM_PINS+1 returns, in bit n, the pin n input delayed by two clock edges. This holds whether the pin is driving or not.
- R4: The latch word at address NUM_PINS+2 returns, in bit n, the output latch of pin n.
- R5: The trigger mode is written {m2,m1,m0}. When m1=0 the pin is edge-triggered: with m2=1 any change sets status; with m2=0 and m0=1 a rise (previous sample 0, current 1) sets it; with m2=0 and m0=0 a fall sets it.
- R6: When m1=1 the pin is level-triggered. Status is set on every cycle in which the synchronized input equals m0, so a clear does not hold while the level remains.
- R7: Status latches whether or not the enable is set. `irq_o` is high exactly when some pin has both status and enable set.
- R8: A control-word write with bit12 = 1 clears that pin's status. A write with bit12 = 0 leaves the status unchanged.
- R9: The status word at address NUM_PINS returns the status of pin n in bit n. Writing it clears the status of every pin whose bit is written 1 and leaves the others unchanged.
- R10: When a clear (from either path) and a new event fall on the same clock edge, the status ends up set.
- R11: `pin_o[n]` and `pin_oe_o[n]` follow the latch and direction of pin n. A single write that sets both changes both outputs on the same edge, so the pin never drives a stale latch value.
- R12: A one-cycle `soft_rst_i` clears the enable, trigger mode and status of every pin. Pins with keep = 1 retain their latch, direction and keep bit. All other pins return to latch 0 and direction input. Soft reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, honours per-pin keep |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pin_i | input | NUM_PINS | Pad inputs |
| pin_o | output | NUM_PINS | Pad output values |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | 1 | Summary interrupt |

## Verification
The delicate case is a software clear that lands on the same clock edge as a newly detected event. The status must stay set in that case, or the event is lost. The bench provokes this by changing a both-edge pin at a known negedge and then counting the two synchronizer edges. It then times both the per-pin clear and the bank-wide clear to arrive exactly on the edge where the event is recorded. It judges the result by reading the status afterwards and comparing it against a plain clear with no event, which must read 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int CTRL_W = 32;
  // control word field positions
  localparam int B_OUT  = 0;
  localparam int B_DIR  = 1;
  localparam int B_EN   = 2;
  localparam int B_MODE = 3;
  localparam int B_KEEP = 6;
  localparam int B_STAT = 12;
  localparam int B_IN   = 13;
  localparam int CFG_W  = B_KEEP + 1;

  // {m2,m1,m0}: m2 any edge, m1 level, m0 high/rising
  typedef struct packed {
    logic both;
    logic level;
    logic high;
  } trig_mode_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_bank_pkg::*;
(
  input  trig_mode_t mode_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);
  always_comb begin
    if (mode_i.level)     hit_o = (cur_i == mode_i.high);
    else if (mode_i.both) hit_o = cur_i ^ prev_i;
    else if (mode_i.high) hit_o = cur_i & ~prev_i;
    else                  hit_o = ~cur_i & prev_i;
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              pin_clr_i,
  input  logic              bank_clr_i,
  input  logic              sync_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              status_o,
  output logic              en_o,
  output logic              out_o,
  output logic              dir_o
);
  logic       out_q, dir_q, en_q, keep_q, prev_q, status_q;
  logic       hit, clr;
  trig_mode_t mode_q;

  gpio_trig_detect i_det (
    .mode_i (mode_q),
    .cur_i  (sync_i),
    .prev_i (prev_q),
    .hit_o  (hit)
  );

  assign clr = pin_clr_i | bank_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= 1'b0;
      dir_q    <= 1'b0;
      en_q     <= 1'b0;
      keep_q   <= 1'b0;
      mode_q   <= '0;
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (soft_rst_i) begin
        if (!keep_q) begin
          out_q <= 1'b0;
          dir_q <= 1'b0;
        end
        en_q     <= 1'b0;
        mode_q   <= '0;
        status_q <= 1'b0;
      end else begin
        if (cfg_we_i) begin
          out_q  <= cfg_i[B_OUT];
          dir_q  <= cfg_i[B_DIR];
          en_q   <= cfg_i[B_EN];
          mode_q <= trig_mode_t'(cfg_i[B_MODE +: 3]);
          keep_q <= cfg_i[B_KEEP];
        end
        // a new event wins over a clear on the same edge
        status_q <= hit | (status_q & ~clr);
      end
    end
  end

  always_comb begin
    ctrl_o               = '0;
    ctrl_o[B_OUT]        = out_q;
    ctrl_o[B_DIR]        = dir_q;
    ctrl_o[B_EN]         = en_q;
    ctrl_o[B_MODE +: 3]  = mode_q;
    ctrl_o[B_KEEP]       = keep_q;
    ctrl_o[B_STAT]       = status_q;
    ctrl_o[B_IN]         = sync_i;
  end

  assign status_o = status_q;
  assign en_o     = en_q;
  assign out_o    = out_q;
  assign dir_o    = dir_q;

  // R8
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !hit && !soft_rst_i) |=> !status_q);
  // R10
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !soft_rst_i) |=> status_q);
  // R12
  keep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && keep_q) |=> ($stable(out_q) && $stable(dir_q)));
  // R12
  drop_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !keep_q) |=> (!out_q && !dir_q));
  // R12
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!status_q && !en_q));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = $clog2(NUM_PINS + 3)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [CTRL_W-1:0]   reg_wdata_i,
  output logic [CTRL_W-1:0]   reg_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int IDX_W = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(NUM_PINS + 1);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(NUM_PINS + 2);

  logic [NUM_PINS-1:0] sync_vec, status_vec, en_vec;
  logic [CTRL_W-1:0]   ctrl_words [NUM_PINS];
  logic                stat_we;

  gpio_in_sync #(.W(NUM_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_vec)
  );

  assign stat_we = reg_we_i && (reg_addr_i == A_STAT);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel;
    assign sel = reg_we_i && (reg_addr_i == ADDR_W'(p));

    gpio_pin_cell i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .cfg_we_i   (sel),
      .cfg_i      (reg_wdata_i[CFG_W-1:0]),
      .pin_clr_i  (sel & reg_wdata_i[B_STAT]),
      .bank_clr_i (stat_we & reg_wdata_i[p]),
      .sync_i     (sync_vec[p]),
      .ctrl_o     (ctrl_words[p]),
      .status_o   (status_vec[p]),
      .en_o       (en_vec[p]),
      .out_o      (pin_o[p]),
      .dir_o      (pin_oe_o[p])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < ADDR_W'(NUM_PINS))
      reg_rdata_o = ctrl_words[reg_addr_i[IDX_W-1:0]];
    else if (reg_addr_i == A_STAT)
      reg_rdata_o = CTRL_W'(status_vec);
    else if (reg_addr_i == A_IN)
      reg_rdata_o = CTRL_W'(sync_vec);
    else if (reg_addr_i == A_OUT)
      reg_rdata_o = CTRL_W'(pin_o);
  end

  assign irq_o = |(status_vec & en_vec);

  // R7
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_vec != '0));
  // R12
  soft_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !irq_o);
endmodule

// File: tb/test_gpio_bank_irq.sv
module test_gpio_bank_irq;
  localparam int NP = 32;
  localparam int A_STAT = NP, A_IN = NP + 1, A_OUT = NP + 2;

  logic          clk = 1'b0;
  logic          rst_n, soft_rst, we;
  logic [5:0]    addr;
  logic [31:0]   wdata, rdata;
  logic [NP-1:0] pin, pout, poe;
  logic          irq;
  int            checks = 0, failures = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_irq i_gpio_bank_irq (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_i(pin), .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  function automatic logic [31:0] cw(logic o, logic d, logic e, logic [2:0] m, logic k, logic c);
    logic [31:0] w = '0;
    w[0] = o; w[1] = d; w[2] = e; w[5:3] = m; w[6] = k; w[12] = c;
    return w;
  endfunction

  function automatic logic exp_event(logic [2:0] m, logic o, logic n);
    if (m[1]) return (o == m[0]) || (n == m[0]);
    if (m[2]) return o != n;
    if (m[0]) return !o && n;
    return o && !n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = a[5:0]; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = a[5:0]; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_pulse();
    soft_rst = 1'b1; @(posedge clk); @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; soft_rst = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin = '0;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(0, d);      chk("R1 ctrl0", d, 0);
    rd(31, d);     chk("R1 ctrl31", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_OUT, d);  chk("R1 latch", d, 0);
    chk("R1 oe", poe, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R11 latch and direction change together; R2 unused bits; R4 readback
    chk("R11 before", {30'b0, poe[5], pout[5]}, 0);
    wr(5, 32'h0000_0F80 | cw(1, 1, 0, 3'b000, 1, 0));
    chk("R11 after", {30'b0, poe[5], pout[5]}, 32'h3);
    rd(5, d);      chk("R2 ctrl fields", d, 32'h43);
    rd(A_OUT, d);  chk("R4 latch bit", {31'b0, d[5]}, 1);
    // R3 input word shows pad, not latch, and lags two edges
    rd(A_IN, d);   chk("R3 driving pin reads pad", {31'b0, d[5]}, 0);
    pin[5] = 1'b1; @(posedge clk); @(negedge clk);
    rd(A_IN, d);   chk("R3 one edge", {31'b0, d[5]}, 0);
    @(posedge clk); @(negedge clk);
    rd(A_IN, d);   chk("R3 two edges", {31'b0, d[5]}, 1);
    rd(5, d);      chk("R2 input bit13", d, 32'h2043);

    // R12 soft reset honours keep
    wr(6, cw(1, 1, 1, 3'b011, 0, 0));
    chk("R12 pin6 driving", {31'b0, poe[6]}, 1);
    soft_pulse();
    rd(5, d);      chk("R12 kept pin", d, 32'h2043);
    rd(6, d);      chk("R12 dropped pin", d, 0);
    chk("R12 pads", {30'b0, poe[6], pout[6]}, 0);
    rd(A_STAT, d); chk("R12 status cleared", d, 0);

    // R6 level high on pin 8, R7 enable gating, R9 bank clear
    wr(8, cw(0, 0, 0, 3'b011, 0, 1));
    pin[8] = 1'b1; idle(4);
    rd(A_STAT, d); chk("R6 level set", {31'b0, d[8]}, 1);
    chk("R7 latched while disabled", {31'b0, irq}, 0);
    wr(8, cw(0, 0, 0, 3'b011, 0, 1)); idle(1);
    rd(A_STAT, d); chk("R6 level re-sets after clear", {31'b0, d[8]}, 1);
    wr(8, cw(0, 0, 1, 3'b011, 0, 0));
    chk("R7 irq on enable", {31'b0, irq}, 1);
    pin[8] = 1'b0; idle(4);
    wr(A_STAT, 32'h0000_0200); idle(1);
    rd(A_STAT, d); chk("R9 unwritten bit kept", {31'b0, d[8]}, 1);
    wr(A_STAT, 32'h0000_0100); idle(1);
    rd(A_STAT, d); chk("R9 bank clear", {31'b0, d[8]}, 0);
    chk("R7 irq after clear", {31'b0, irq}, 0);
    wr(8, cw(0, 0, 0, 3'b000, 0, 1));

    // R8 write-one-to-clear on pin 9 (rising)
    wr(9, cw(0, 0, 0, 3'b001, 0, 1));
    pin[9] = 1'b1; idle(4);
    rd(A_STAT, d); chk("R5 rising", {31'b0, d[9]}, 1);
    wr(9, cw(0, 0, 0, 3'b001, 0, 0)); idle(1);
    rd(A_STAT, d); chk("R8 zero keeps", {31'b0, d[9]}, 1);
    wr(9, cw(0, 0, 0, 3'b001, 0, 1)); idle(1);
    rd(A_STAT, d); chk("R8 one clears", {31'b0, d[9]}, 0);

    // R5 any-edge mode catches a fall
    pin[10] = 1'b1; wr(10, cw(0, 0, 0, 3'b100, 0, 0)); idle(4);
    wr(10, cw(0, 0, 0, 3'b100, 0, 1));
    pin[10] = 1'b0; idle(4);
    rd(A_STAT, d); chk("R5 any-edge fall", {31'b0, d[10]}, 1);

    // R10 clear and event on the same edge, pin 11 any-edge
    wr(11, cw(0, 0, 1, 3'b101, 0, 1));
    pin[11] = 1'b1; idle(4);
    rd(A_STAT, d); chk("R10 setup", {31'b0, d[11]}, 1);
    pin[11] = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    wr(11, cw(0, 0, 1, 3'b101, 0, 1));
    rd(A_STAT, d); chk("R10 per-pin clear collides", {31'b0, d[11]}, 1);
    wr(11, cw(0, 0, 1, 3'b101, 0, 1));
    rd(A_STAT, d); chk("R8 clear without event", {31'b0, d[11]}, 0);
    pin[11] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    wr(A_STAT, 32'h0000_0800);
    rd(A_STAT, d); chk("R10 bank clear collides", {31'b0, d[11]}, 1);
    chk("R7 irq from collision", {31'b0, irq}, 1);
    wr(11, cw(0, 0, 0, 3'b101, 0, 1));

    // random trigger-mode sweep
    soft_pulse();
    for (int it = 0; it < 80; it++) begin
      int         p;
      logic [2:0] m;
      logic       o, n, e, x;
      p = $urandom_range(0, NP - 1);
      m = 3'($urandom);
      o = 1'($urandom); n = 1'($urandom); e = 1'($urandom);
      pin[p] = o; idle(4);
      wr(p, cw(0, 0, 0, m, 0, 0)); idle(2);
      wr(p, cw(0, 0, e, m, 0, 1));
      pin[p] = n; idle(4);
      x = exp_event(m, o, n);
      rd(A_STAT, d);
      chk(m[1] ? "R6 random level" : "R5 random edge", {31'b0, d[p]}, {31'b0, x});
      chk("R7 random irq", {31'b0, irq}, {31'b0, x & e});
      rd(A_IN, d);   chk("R3 random input", {31'b0, d[p]}, {31'b0, n});
      wr(p, cw(0, 0, 0, m, 0, 1));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule